// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps time of day and calendar in BCD. The fields are seconds, minutes, hours, day of week, day of month, month, two-digit year and a century flag. A one-cycle `tick` pulse, once per second, advances the count. A separate prescaler produces that pulse. Software sets the fields through a byte-wide write strobe and reads them back as seven packed register bytes, or one byte at a time through `rd_addr`/`rd_data`.

The block holds two copies of the time. The running copy advances on every accepted tick. The visible copy is what the outputs show. While `rd_busy` is high, a host is reading the registers, so the visible copy stays frozen and no byte changes in the middle of a multi-byte read. Ticks that arrive during the freeze still advance the running copy, so no second is lost. The visible copy catches up on the first clock edge after `rd_busy` falls. If `rd_busy` stays high longer than `HOLD_MAX` cycles, the visible copy is refreshed anyway.

There is no data stream here, so every pin is a plain level or strobe and there is no back-pressure. A write is always accepted in the cycle it is presented.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the register bytes read 00, 00, 00, 01, 01, 01, 00 for addresses 0 to 6. The halt flag, the century-enable flag and the century flag are all 0.
- R2: Each accepted tick adds one second in BCD. Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00.
- R3: When the hours wrap, the day of week (address 3, bits 2:0) steps 1 to 7 and then back to 1. On the same edge the date advances.
- R4: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in months 01, 03, 05, 07, 08, 10 and 12. A date wrap advances the month, and month 12 wraps to 01.
- R5: February wraps after 29 when the BCD year is a multiple of 4 (00 counts as one), and after 28 otherwise.
- R6: When the year wraps from 99 to 00, the century flag (address 2, bit 6) inverts if the century-enable flag (address 2, bit 7) is 1. If that enable flag is 0, the century flag never changes.
- R7: While the halt flag (address 0, bit 7) is 1, ticks have no effect on any field. Clearing the flag lets the next tick count again.
- R8: A write loads the addressed field, and bits with no field read back as 0. The result shows in both copies on the next edge. A tick in the same cycle as a write is dropped. A write to address 7 changes nothing.
- R9: While `rd_busy` is 1, the visible bytes do not change except by a write or by R10. Ticks accepted during that time are all applied on the first edge where `rd_busy` is 0.
- R10: A visible update that has been held for `HOLD_MAX` edges after its tick edge is applied on that edge, even if `rd_busy` is still 1.
- R11: `rd_data` shows the visible byte at `rd_addr` in the same cycle, and shows 0 for address 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse marking one elapsed second |
| rd_busy | input | 1 | High while a host reads the registers; freezes the visible copy |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 3 | Register address for `rd_data` |
| rd_data | output | 8 | Visible byte at `rd_addr` |
| regs_o | output | 56 | Visible bytes, address n at bits 8n+7:8n |

## Verification
Latencies are as follows:
- An accepted tick or a write changes the visible bytes on the next rising edge.
- A tick taken while `rd_busy` is high appears on the first edge where `rd_busy` is low, or at the latest `HOLD_MAX` edges after the tick edge.
- `rd_data` follows `rd_addr` with no register between them.

A reference model steps once per rising edge from the same inputs. The bench drives inputs on the falling edge and compares every output byte with the model on the next falling edge. Each result is therefore checked in exactly the cycle it is due. Directed checks at the calendar boundaries compare against constant expected bytes.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  typedef struct packed {
    logic       halt;
    logic [6:0] sec;
    logic [6:0] min;
    logic       cen_en;
    logic       cen;
    logic [5:0] hour;
    logic [2:0] dow;
    logic [5:0] date;
    logic [4:0] month;
    logic [7:0] year;
  } cal_t;

  localparam cal_t CAL_RESET = '{halt: 1'b0, sec: 7'h00, min: 7'h00, cen_en: 1'b0,
                                 cen: 1'b0, hour: 6'h00, dow: 3'd1, date: 6'h01,
                                 month: 5'h01, year: 8'h00};

  // BCD increment with wrap from 'last' back to 'first'
  function automatic logic [7:0] bcd_step(input logic [7:0] v, input logic [7:0] last,
                                          input logic [7:0] first);
    if (v == last) return first;
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // multiple of 4: even tens needs units 0/4/8, odd tens needs units 2/6
  function automatic logic year_is_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_last(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02: return year_is_leap(y) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] reg_byte(input cal_t s, input logic [2:0] a);
    case (a)
      3'd0: return {s.halt, s.sec};
      3'd1: return {1'b0, s.min};
      3'd2: return {s.cen_en, s.cen, s.hour};
      3'd3: return {5'b0, s.dow};
      3'd4: return {2'b0, s.date};
      3'd5: return {3'b0, s.month};
      3'd6: return s.year;
      default: return 8'h00;
    endcase
  endfunction

  function automatic cal_t apply_write(input cal_t s, input logic [2:0] a, input logic [7:0] d);
    cal_t r = s;
    case (a)
      3'd0: begin r.halt = d[7]; r.sec = d[6:0]; end
      3'd1: r.min = d[6:0];
      3'd2: begin r.cen_en = d[7]; r.cen = d[6]; r.hour = d[5:0]; end
      3'd3: r.dow = d[2:0];
      3'd4: r.date = d[5:0];
      3'd5: r.month = d[4:0];
      3'd6: r.year = d;
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bcd_cal_advance.sv
module bcd_cal_advance
  import bcd_cal_pkg::*;
(
  input  cal_t cur,
  output cal_t nxt
);
  logic c_sec, c_min, c_hour, c_date, c_month, c_year;

  always_comb begin
    nxt     = cur;
    c_sec   = (cur.sec == 7'h59);
    c_min   = c_sec && (cur.min == 7'h59);
    c_hour  = c_min && (cur.hour == 6'h23);
    c_date  = c_hour && ({2'b0, cur.date} == month_last(cur.month, cur.year));
    c_month = c_date && (cur.month == 5'h12);
    c_year  = c_month && (cur.year == 8'h99);

    nxt.sec = 7'(bcd_step({1'b0, cur.sec}, 8'h59, 8'h00));
    if (c_sec) nxt.min = 7'(bcd_step({1'b0, cur.min}, 8'h59, 8'h00));
    if (c_min) nxt.hour = 6'(bcd_step({2'b0, cur.hour}, 8'h23, 8'h00));
    if (c_hour) begin
      nxt.dow  = (cur.dow == 3'd7) ? 3'd1 : cur.dow + 3'd1;
      nxt.date = 6'(bcd_step({2'b0, cur.date}, month_last(cur.month, cur.year), 8'h01));
    end
    if (c_date) nxt.month = 5'(bcd_step({3'b0, cur.month}, 8'h12, 8'h01));
    if (c_month) nxt.year = bcd_step(cur.year, 8'h99, 8'h00);
    if (c_year && cur.cen_en) nxt.cen = ~cur.cen;
  end
endmodule

// File: rtl/bcd_cal_hold.sv
module bcd_cal_hold #(
  parameter int HOLD_MAX = 12_500_000,
  parameter int CNT_W    = $clog2(HOLD_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_apply,
  input  logic rd_busy,
  input  logic wr_en,
  output logic vis_load,
  output logic expire
);
  logic             pending_q;
  logic [CNT_W-1:0] cnt_q;

  assign expire   = pending_q && rd_busy && (cnt_q == CNT_W'(HOLD_MAX - 1));
  assign vis_load = (tick_apply || pending_q) && (!rd_busy || expire);

  always_ff @(posedge clk) begin
    if (!rst_n || wr_en || vis_load) begin
      pending_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      pending_q <= pending_q || tick_apply;
      cnt_q     <= (pending_q && rd_busy) ? cnt_q + 1'b1 : '0;
    end
  end

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |-> (cnt_q < CNT_W'(HOLD_MAX))); // R10
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !rd_busy) |=> !pending_q); // R9
endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
  import bcd_cal_pkg::*;
#(
  parameter int HOLD_MAX = 12_500_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        rd_busy,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [2:0]  rd_addr,
  output logic [7:0]  rd_data,
  output logic [55:0] regs_o
);
  localparam int NUM_REGS = 7;
  localparam int CNT_W    = $clog2(HOLD_MAX + 1);

  cal_t run_q, vis_q, run_nxt, run_wr;
  logic tick_apply, vis_load, expire;
  logic [7:0] vbyte [8];

  assign tick_apply = tick && !run_q.halt && !wr_en;
  assign run_wr     = apply_write(run_q, wr_addr, wr_data);

  bcd_cal_advance u_adv (.cur(run_q), .nxt(run_nxt));

  bcd_cal_hold #(.HOLD_MAX(HOLD_MAX), .CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .tick_apply(tick_apply), .rd_busy(rd_busy),
    .wr_en(wr_en), .vis_load(vis_load), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= CAL_RESET;
      vis_q <= CAL_RESET;
    end else if (wr_en) begin
      run_q <= run_wr;
      vis_q <= run_wr;
    end else begin
      if (tick_apply) run_q <= run_nxt;
      if (vis_load) vis_q <= tick_apply ? run_nxt : run_q;
    end
  end

  for (genvar gi = 0; gi < 8; gi++) begin : g_bytes
    if (gi < NUM_REGS) begin : g_reg
      assign vbyte[gi] = reg_byte(vis_q, 3'(gi));
      assign regs_o[gi*8 +: 8] = vbyte[gi];
    end else begin : g_pad
      assign vbyte[gi] = 8'h00;
    end
  end

  assign rd_data = vbyte[rd_addr];

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q.halt && !wr_en) |=> $stable(run_q)); // R7
  AST_VIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && !wr_en && !expire) |=> $stable(vis_q)); // R9
  AST_CEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q.cen_en && !wr_en) |=> $stable(run_q.cen)); // R6
  AST_DOW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_apply && run_q.dow != 3'd0) |=> (run_q.dow != 3'd0)); // R3
endmodule

// File: tb/tb_bcd_calendar_core.sv
module tb_bcd_calendar_core;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 6;

  logic clk = 0, rst_n = 0, tick = 0, rd_busy = 0, wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [55:0] regs_o;
  int total = 0, bad = 0;
  string tag = "R1";
  bit done = 0;

  // reference model (binary integers)
  int m_halt = 0, m_sec = 0, m_min = 0, m_ceb = 0, m_cb = 0, m_hr = 0;
  int m_dow = 1, m_date = 1, m_mon = 1, m_yr = 0;
  int m_pend = 0, m_cnt = 0;
  logic [7:0] mv [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_calendar_core #(.HOLD_MAX(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rd_busy(rd_busy), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .regs_o(regs_o)
  );

  function automatic logic [7:0] tobcd(int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction
  function automatic int frombcd(logic [7:0] d);
    return int'(d[7:4]) * 10 + int'(d[3:0]);
  endfunction
  function automatic int mdays(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic pack_model();
    mv[0] = {1'(m_halt), 7'(tobcd(m_sec))};
    mv[1] = tobcd(m_min);
    mv[2] = {1'(m_ceb), 1'(m_cb), 6'(tobcd(m_hr))};
    mv[3] = 8'(m_dow);
    mv[4] = tobcd(m_date);
    mv[5] = tobcd(m_mon);
    mv[6] = tobcd(m_yr);
    mv[7] = 8'h00;
  endtask

  task automatic model_advance();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0;
          m_dow = (m_dow == 7) ? 1 : m_dow + 1;
          if (m_date == mdays(m_mon, m_yr)) begin
            m_date = 1;
            if (m_mon == 12) begin
              m_mon = 1;
              if (m_yr == 99) begin m_yr = 0; if (m_ceb != 0) m_cb ^= 1; end
              else m_yr++;
            end else m_mon++;
          end else m_date++;
        end
      end
    end
  endtask

  task automatic model_step(bit t, bit b, bit w, logic [2:0] a, logic [7:0] d);
    bit applied, expd, load;
    if (w) begin
      case (a)
        3'd0: begin m_halt = d[7]; m_sec = frombcd({1'b0, d[6:0]}); end
        3'd1: m_min = frombcd({1'b0, d[6:0]});
        3'd2: begin m_ceb = d[7]; m_cb = d[6]; m_hr = frombcd({2'b0, d[5:0]}); end
        3'd3: m_dow = int'(d[2:0]);
        3'd4: m_date = frombcd({2'b0, d[5:0]});
        3'd5: m_mon = frombcd({3'b0, d[4:0]});
        3'd6: m_yr = frombcd(d);
        default: ;
      endcase
      pack_model(); m_pend = 0; m_cnt = 0;
    end else begin
      applied = t && (m_halt == 0);
      expd = (m_pend != 0) && b && (m_cnt == HOLD - 1);
      load = (applied || m_pend != 0) && (!b || expd);
      if (applied) model_advance();
      if (load) begin pack_model(); m_pend = 0; m_cnt = 0; end
      else begin
        m_cnt = (m_pend != 0 && b) ? m_cnt + 1 : 0;
        if (applied) m_pend = 1;
      end
    end
  endtask

  task automatic compare_all();
    total++;
    if (regs_o !== {mv[6], mv[5], mv[4], mv[3], mv[2], mv[1], mv[0]}) begin
      bad++;
      $display("FAIL %s regs actual=%h expected=%h", tag, regs_o,
               {mv[6], mv[5], mv[4], mv[3], mv[2], mv[1], mv[0]});
    end
    total++;
    if (rd_data !== mv[rd_addr]) begin
      bad++;
      $display("FAIL R11 rd_data addr=%0d actual=%h expected=%h", rd_addr, rd_data, mv[rd_addr]);
    end
  endtask

  task automatic chk(string t, int idx, logic [7:0] exp);
    total++;
    if (regs_o[idx*8 +: 8] !== exp) begin
      bad++;
      $display("FAIL %s byte%0d actual=%h expected=%h", t, idx, regs_o[idx*8 +: 8], exp);
    end
  endtask

  task automatic cyc(bit t, bit b, bit w, logic [2:0] a, logic [7:0] d);
    tick = t; rd_busy = b; wr_en = w; wr_addr = a; wr_data = d;
    @(posedge clk);
    model_step(t, b, w, a, d);
    @(negedge clk);
    compare_all();
    rd_addr = rd_addr + 3'd1;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    cyc(0, 0, 1, a, d);
  endtask

  task automatic set_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] dw,
                          logic [7:0] dt, logic [7:0] mo, logic [7:0] y);
    wr(0, s); wr(1, mi); wr(2, h); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, y);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    pack_model();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R1";
    compare_all();
    chk("R1", 3, 8'h01); chk("R1", 4, 8'h01); chk("R1", 0, 8'h00);

    // R2 R3 R5: non-leap February end, with day-of-week wrap 7 -> 1
    tag = "R2";
    set_time(8'h58, 8'h59, 8'hA3, 8'h07, 8'h28, 8'h02, 8'h03);
    cyc(1, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
    chk("R2", 0, 8'h59);
    cyc(1, 0, 0, 0, 0);
    chk("R2", 0, 8'h00); chk("R2", 1, 8'h00); chk("R2", 2, 8'h80);
    chk("R3", 3, 8'h01); chk("R5", 4, 8'h01); chk("R5", 5, 8'h03);

    // R5: leap February keeps the 29th
    tag = "R5";
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h04);
    cyc(1, 0, 0, 0, 0);
    chk("R5", 4, 8'h29); chk("R5", 5, 8'h02); chk("R3", 3, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00);
    cyc(1, 0, 0, 0, 0);
    chk("R5", 4, 8'h29);

    // R4: 30-day and 31-day months
    tag = "R4";
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h30, 8'h04, 8'h21);
    cyc(1, 0, 0, 0, 0);
    chk("R4", 4, 8'h01); chk("R4", 5, 8'h05);
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h30, 8'h07, 8'h21);
    cyc(1, 0, 0, 0, 0);
    chk("R4", 4, 8'h31);

    // R6: century toggle enabled and disabled
    tag = "R6";
    set_time(8'h59, 8'h59, 8'hA3, 8'h05, 8'h31, 8'h12, 8'h99);
    cyc(1, 0, 0, 0, 0);
    chk("R6", 6, 8'h00); chk("R6", 5, 8'h01); chk("R6", 2, 8'hC0);
    set_time(8'h59, 8'h59, 8'h63, 8'h05, 8'h31, 8'h12, 8'h99);
    cyc(1, 0, 0, 0, 0);
    chk("R6", 6, 8'h00); chk("R6", 2, 8'h40);

    // R7: halt flag freezes the count
    tag = "R7";
    wr(0, 8'h90);
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0);
    chk("R7", 0, 8'h90);
    wr(0, 8'h10);
    cyc(1, 0, 0, 0, 0);
    chk("R7", 0, 8'h11);

    // R8: unused bits read 0, tick dropped under write, address 7 inert
    tag = "R8";
    wr(3, 8'hFF); chk("R8", 3, 8'h07);
    wr(5, 8'hF2); chk("R8", 5, 8'h12);
    wr(1, 8'hC5); chk("R8", 1, 8'h45);
    cyc(1, 0, 1, 3'd4, 8'h17);
    chk("R8", 4, 8'h17); chk("R8", 0, 8'h11);
    wr(7, 8'hFF); chk("R8", 1, 8'h45);

    // R9: hold during read, no seconds lost
    tag = "R9";
    wr(0, 8'h20);
    cyc(1, 1, 0, 0, 0); chk("R9", 0, 8'h20);
    cyc(0, 1, 0, 0, 0);
    cyc(1, 1, 0, 0, 0); chk("R9", 0, 8'h20);
    cyc(0, 0, 0, 0, 0); chk("R9", 0, 8'h22);

    // R10: forced update after HOLD edges
    tag = "R10";
    cyc(1, 1, 0, 0, 0);
    for (int i = 1; i < HOLD; i++) cyc(0, 1, 0, 0, 0);
    chk("R10", 0, 8'h22);
    cyc(0, 1, 0, 0, 0); chk("R10", 0, 8'h23);
    cyc(0, 0, 0, 0, 0);

    // R11: address 7 reads zero
    tag = "R11";
    rd_addr = 3'd7; #1;
    total++;
    if (rd_data !== 8'h00) begin
      bad++; $display("FAIL R11 addr7 actual=%h expected=00", rd_data);
    end

    // mixed run for R2
    tag = "R2";
    set_time(8'h00, 8'h58, 8'h22, 8'h01, 8'h10, 8'h10, 8'h50);
    for (int i = 0; i < 200; i++) cyc(1, (i % 7) < 2, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule